// File: doc/BRIEF.md
# Compare-Match Timer Channel

One up-counting timer channel with a byte-wide register port. Software selects a prescale ratio for the internal clock, a counter clear source and a pin action, then loads a compare value and sets this channel's bit in a start vector that several channels share. While the channel runs, each count tick increments the counter. When the counter equals the compare value on a tick, a match event occurs. The event sets a sticky flag, can raise the interrupt line, and can clear, set or toggle the compare output pin.

The usual use is a periodic tick source. Software selects clear-on-compare, loads the compare value and starts the channel. The counter then runs from 0 to the compare value and wraps to 0, so the period is the compare value plus one ticks. Software acknowledges each match by reading the status register and then writing 0 to the flag bit. The counter can be read and written at any time, and a software write takes priority over counting.

Top module: `cmt_channel`

## Requirements
- R1: After reset every register reads 0 except the compare bytes, which read 0xFF. The counter is 0 and `cmp_pin`, `cmp_pin_oe` and `irq` are 0.
- R2: The counter changes only by a software write while `start_vec[CH_IDX]` is 0. The prescale divider restarts from zero each time the bit goes back to 1.
- R3: Control bits [2:0] select the tick rate. Code 0 ticks on every running cycle; codes 1, 2 and 3 tick on every 4th, 16th and 64th running cycle, counted from the cycle the start bit rose. Codes 4 to 7 give no ticks.
- R4: If control bits [7:5] equal 1, a match tick loads 0 into the counter, so the count runs 0..compare. Every other code lets the counter run freely and wrap from 0xFFFF to 0.
- R5: A tick on which the counter equals the compare value is a match event, and it sets status bit 0 on that clock edge.
- R6: Status bit 0 clears only on a write with data bit 0 = 0 that follows a read of the status register which returned the flag set. Any status write ends this armed state. Writing 1, or writing 0 without the prior read, leaves the flag set. A match in the same cycle keeps the flag set.
- R7: `irq` is 1 exactly when status bit 0 and interrupt-enable bit 0 (offset 4) are both 1.
- R8: The low nibble of the I/O control register (offset 2) drives the pin. Codes 1, 2 and 3 load level 0 when written; codes 5, 6 and 7 load level 1. On a match, code bits [1:0] = 1, 2 or 3 drive the level to 0, to 1, or toggle it. Codes 0 and 4 hold `cmp_pin_oe` and `cmp_pin` at 0. The high nibble is storage only.
- R9: A write to a counter byte in a tick cycle stores the written byte, leaves the other byte unchanged, and causes no increment, clear or match event.
- R10: Byte map: control 0, mode 1 (low 4 bits kept, high bits read 0), I/O control 2, interrupt enable 4, status 5 (only bit 0 is used), counter high/low bytes 6/7, compare high/low bytes 8/9. All other offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register byte write strobe |
| reg_rd | input | 1 | Register byte read strobe (arms the flag clear) |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| start_vec | input | N_CH | Shared start vector; bit CH_IDX runs this channel |
| cmp_pin | output | 1 | Compare output level |
| cmp_pin_oe | output | 1 | Compare output enable |
| irq | output | 1 | Compare-match interrupt request |

## Verification
Register writes and match events take effect on the next clock edge, so the flag, pin level, enable and `irq` are all due one cycle after the write or the match tick. Read data is combinational and is due in the same cycle. The bench drives inputs on the falling edge. It keeps the start bit high for an exact number of rising edges and computes the expected count from that number, the prescale ratio and the clear rule. It samples outputs on the falling edge after the edge that updates them. The counter-write priority test places the write in the same cycle as a running tick.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

   localparam int BYTE_W   = 8;

   localparam int OFF_CTRL = 0;
   localparam int OFF_MODE = 1;
   localparam int OFF_IOC  = 2;
   localparam int OFF_IER  = 4;
   localparam int OFF_STAT = 5;
   localparam int OFF_CNT  = 6;
   localparam int OFF_CMP  = 8;

   typedef enum logic [2:0] {
      CLR_NONE = 3'd0,
      CLR_ON_A = 3'd1,
      CLR_ON_B = 3'd2,
      CLR_SYNC = 3'd3,
      CLR_ON_C = 3'd5,
      CLR_ON_D = 3'd6
   } clr_src_e;

   typedef enum logic [1:0] {
      PIN_KEEP = 2'd0,
      PIN_LOW  = 2'd1,
      PIN_HIGH = 2'd2,
      PIN_FLIP = 2'd3
   } pin_act_e;

   typedef struct packed {
      logic [2:0] clr_src;
      logic [1:0] edge_sel;
      logic [2:0] psc;
   } ctrl_t;

   function automatic logic pin_enabled(input logic [3:0] code);
      return code[1:0] != 2'b00;
   endfunction

   function automatic logic pin_init_level(input logic [3:0] code);
      return code[2];
   endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
   parameter int SEL_W    = 3,
   parameter int N_RATIO  = 4,
   parameter int LOG_STEP = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int DIV_W = LOG_STEP * (N_RATIO - 1);
   localparam int IDX_W = $clog2(N_RATIO);

   initial begin
      assert (N_RATIO >= 2 && (1 << IDX_W) == N_RATIO)
         else $fatal(1, "N_RATIO must be a power of two >= 2");
      assert (SEL_W > IDX_W) else $fatal(1, "SEL_W too narrow");
      assert (LOG_STEP >= 1) else $fatal(1, "LOG_STEP must be >= 1");
   end

   logic [DIV_W-1:0]   div_q;
   logic [N_RATIO-1:0] hit;
   logic               sel_ok;

   generate
      for (genvar k = 0; k < N_RATIO; k++) begin : g_ratio
         if (k == 0) begin : g_full
            assign hit[k] = 1'b1;
         end else begin : g_div
            assign hit[k] = &div_q[k*LOG_STEP-1:0];
         end
      end
   endgenerate

   // divider runs only while the channel is started; restarts from zero
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_q <= '0;
      else if (!run)   div_q <= '0;
      else             div_q <= div_q + 1'b1;
   end

   assign sel_ok = ~|sel[SEL_W-1:IDX_W];
   assign tick   = run && sel_ok && hit[sel[IDX_W-1:0]];

   // R3: a divided ratio never ticks on the first running cycle
   p_first_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(run) && sel != '0) |-> !tick);

endmodule

// File: rtl/cmt_counter.sv
module cmt_counter
   import cmt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        tick,
   input  logic                        clr_on_match,
   input  logic [CNT_W/BYTE_W-1:0]     byte_we,
   input  logic [BYTE_W-1:0]           wdata,
   input  logic [CNT_W-1:0]            cmp,
   output logic [CNT_W-1:0]            cnt_q,
   output logic                        match_evt
);
   localparam int NB = CNT_W / BYTE_W;

   initial begin
      assert (CNT_W % BYTE_W == 0 && NB >= 1)
         else $fatal(1, "CNT_W must be a whole number of bytes");
   end

   logic             wr_any;
   logic [CNT_W-1:0] cnt_d;

   assign wr_any    = |byte_we;
   assign match_evt = tick && !wr_any && (cnt_q == cmp);

   always_comb begin
      cnt_d = cnt_q;
      if (wr_any) begin
         for (int i = 0; i < NB; i++) begin
            if (byte_we[i]) cnt_d[CNT_W-1-BYTE_W*i -: BYTE_W] = wdata;
         end
      end else if (match_evt && clr_on_match) begin
         cnt_d = '0;
      end else if (tick) begin
         cnt_d = cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   // R2: no tick and no write keeps the count
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_any) |=> $stable(cnt_q));

   // R3: an ordinary tick advances by exactly one
   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_any && !(match_evt && clr_on_match))
      |=> cnt_q == $past(cnt_q) + 1'b1);

   // R4: a clearing match lands on zero
   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (match_evt && clr_on_match) |=> cnt_q == '0);

   generate
      for (genvar b = 0; b < NB; b++) begin : g_wr_chk
         // R9: the written byte wins over counting
         p_wr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            byte_we[b] |=> cnt_q[CNT_W-1-BYTE_W*b -: BYTE_W] == $past(wdata));
      end
   endgenerate

endmodule

// File: rtl/cmt_pin_ctl.sv
module cmt_pin_ctl
   import cmt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] code_q,
   input  logic       code_wr,
   input  logic [3:0] code_new,
   input  logic       evt,
   output logic       pin,
   output logic       pin_oe
);
   logic level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b0;
      end else if (code_wr) begin
         level_q <= pin_init_level(code_new);
      end else if (evt && pin_enabled(code_q)) begin
         case (pin_act_e'(code_q[1:0]))
            PIN_LOW:  level_q <= 1'b0;
            PIN_HIGH: level_q <= 1'b1;
            PIN_FLIP: level_q <= ~level_q;
            default:  level_q <= level_q;
         endcase
      end
   end

   assign pin_oe = pin_enabled(code_q);
   assign pin    = pin_oe & level_q;

   // R8: toggle action inverts the level on a match
   p_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !code_wr && code_q[1:0] == 2'd3) |=> level_q != $past(level_q));

   // R8: writing a code loads its initial level
   p_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
      code_wr |=> level_q == $past(code_new[2]));

endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
   import cmt_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 4,
   parameter int N_CH   = 3,
   parameter int CH_IDX = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic [N_CH-1:0]   start_vec,
   output logic              cmp_pin,
   output logic              cmp_pin_oe,
   output logic              irq
);
   localparam int NB = CNT_W / BYTE_W;

   initial begin
      assert (CH_IDX >= 0 && CH_IDX < N_CH) else $fatal(1, "CH_IDX out of range");
      assert (CNT_W == 8 || CNT_W == 16) else $fatal(1, "CNT_W must be 8 or 16");
      assert (OFF_CMP + NB <= (1 << ADDR_W)) else $fatal(1, "ADDR_W too small");
   end

   ctrl_t            ctrl_q;
   logic [3:0]       mode_q;
   logic [7:0]       ioc_q;
   logic [7:0]       ier_q;
   logic [CNT_W-1:0] cmp_q;
   logic [CNT_W-1:0] cnt_q;
   logic [NB-1:0]    cnt_we;
   logic             flag_q, arm_q;
   logic             tick, match_evt, start;
   logic             stat_wr, stat_rd, ioc_wr;
   logic             unused_start;

   assign start        = start_vec[CH_IDX];
   assign unused_start = ^start_vec;

   assign stat_wr = reg_wr && reg_addr == ADDR_W'(OFF_STAT);
   assign stat_rd = reg_rd && reg_addr == ADDR_W'(OFF_STAT);
   assign ioc_wr  = reg_wr && reg_addr == ADDR_W'(OFF_IOC);

   // ---------------- configuration registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mode_q <= '0;
         ioc_q  <= '0;
         ier_q  <= '0;
      end else if (reg_wr) begin
         if (reg_addr == ADDR_W'(OFF_CTRL)) ctrl_q <= ctrl_t'(reg_wdata);
         if (reg_addr == ADDR_W'(OFF_MODE)) mode_q <= reg_wdata[3:0];
         if (ioc_wr)                        ioc_q  <= reg_wdata;
         if (reg_addr == ADDR_W'(OFF_IER))  ier_q  <= reg_wdata;
      end
   end

   generate
      for (genvar i = 0; i < NB; i++) begin : g_bytes
         assign cnt_we[i] = reg_wr && reg_addr == ADDR_W'(OFF_CNT + i);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cmp_q[CNT_W-1-BYTE_W*i -: BYTE_W] <= '1;
            else if (reg_wr && reg_addr == ADDR_W'(OFF_CMP + i))
               cmp_q[CNT_W-1-BYTE_W*i -: BYTE_W] <= reg_wdata;
         end
      end
   endgenerate

   // ---------------- datapath ----------------
   cmt_prescaler #(
      .SEL_W    (3),
      .N_RATIO  (4),
      .LOG_STEP (2)
   ) u_psc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (start),
      .sel   (ctrl_q.psc),
      .tick  (tick)
   );

   cmt_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .clr_on_match (ctrl_q.clr_src == CLR_ON_A),
      .byte_we      (cnt_we),
      .wdata        (reg_wdata),
      .cmp          (cmp_q),
      .cnt_q        (cnt_q),
      .match_evt    (match_evt)
   );

   cmt_pin_ctl u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .code_q   (ioc_q[3:0]),
      .code_wr  (ioc_wr),
      .code_new (reg_wdata[3:0]),
      .evt      (match_evt),
      .pin      (cmp_pin),
      .pin_oe   (cmp_pin_oe)
   );

   // ---------------- flag and read-then-clear handshake ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         if (match_evt)
            flag_q <= 1'b1;
         else if (stat_wr && arm_q && !reg_wdata[0])
            flag_q <= 1'b0;

         if (stat_wr)
            arm_q <= 1'b0;
         else if (stat_rd && flag_q)
            arm_q <= 1'b1;
      end
   end

   assign irq = flag_q & ier_q[0];

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(OFF_CTRL)) reg_rdata = ctrl_q;
      if (reg_addr == ADDR_W'(OFF_MODE)) reg_rdata = {4'b0, mode_q};
      if (reg_addr == ADDR_W'(OFF_IOC))  reg_rdata = ioc_q;
      if (reg_addr == ADDR_W'(OFF_IER))  reg_rdata = ier_q;
      if (reg_addr == ADDR_W'(OFF_STAT)) reg_rdata = {7'b0, flag_q};
      for (int i = 0; i < NB; i++) begin
         if (reg_addr == ADDR_W'(OFF_CNT + i))
            reg_rdata = cnt_q[CNT_W-1-BYTE_W*i -: BYTE_W];
         if (reg_addr == ADDR_W'(OFF_CMP + i))
            reg_rdata = cmp_q[CNT_W-1-BYTE_W*i -: BYTE_W];
      end
   end

   // R2: a stopped channel keeps its count unless software writes it
   p_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !(|cnt_we)) |=> $stable(cnt_q));

   // R5: a match event leaves the flag set
   p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      match_evt |=> flag_q);

   // R6: the flag only falls through an armed zero write
   p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !(stat_wr && arm_q && !reg_wdata[0])) |=> flag_q);

   // R7: an enabled match raises the interrupt
   p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (match_evt && ier_q[0] && !(reg_wr && reg_addr == ADDR_W'(OFF_IER))) |=> irq);

endmodule

// File: tb/cmt_channel_test.sv
`timescale 1ns/1ps
module cmt_channel_test;

   localparam int CH = 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [2:0] start_vec = '0;
   logic       cmp_pin, cmp_pin_oe, irq;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   always #2 clk = ~clk;

   cmt_channel #(.CNT_W(16), .ADDR_W(4), .N_CH(3), .CH_IDX(CH)) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .start_vec  (start_vec),
      .cmp_pin    (cmp_pin),
      .cmp_pin_oe (cmp_pin_oe),
      .irq        (irq)
   );

   typedef struct packed {
      logic [2:0]  psc;
      logic [2:0]  clr;
      logic [15:0] cmp;
      logic [15:0] init;
      logic [15:0] cyc;
   } vec_t;

   localparam vec_t VECS [9] = '{
      '{3'd0, 3'd0, 16'hFFFF, 16'h0000, 16'd37},
      '{3'd1, 3'd0, 16'hFFFF, 16'h0000, 16'd50},
      '{3'd2, 3'd0, 16'hFFFF, 16'h0000, 16'd100},
      '{3'd3, 3'd0, 16'hFFFF, 16'h0000, 16'd200},
      '{3'd4, 3'd0, 16'hFFFF, 16'h0000, 16'd40},
      '{3'd0, 3'd1, 16'h0009, 16'h0000, 16'd25},
      '{3'd1, 3'd1, 16'h0002, 16'h0000, 16'd30},
      '{3'd0, 3'd2, 16'h0003, 16'h0000, 16'd20},
      '{3'd0, 3'd0, 16'hFFFF, 16'hFFFE, 16'd5}
   };

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got=%0h expected=%0h", tag, got, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic rd16(input logic [3:0] a, output logic [15:0] d);
      logic [7:0] hi, lo;
      rd(a, hi);
      rd(a + 4'd1, lo);
      d = {hi, lo};
   endtask

   task automatic run(input int cycles);
      start_vec[CH] = 1'b1;
      repeat (cycles) @(negedge clk);
      start_vec[CH] = 1'b0;
   endtask

   task automatic setup(input logic [7:0] ctrl, input logic [15:0] cmp, input logic [15:0] cnt);
      wr(4'd0, ctrl);
      wr(4'd8, cmp[15:8]);
      wr(4'd9, cmp[7:0]);
      wr(4'd6, cnt[15:8]);
      wr(4'd7, cnt[7:0]);
   endtask

   function automatic logic [15:0] expect_cnt(input vec_t v);
      int d, t, base, m;
      d = (v.psc < 3'd4) ? (1 << (2 * int'(v.psc))) : 0;
      t = (d == 0) ? 0 : int'(v.cyc) / d;
      base = int'(v.init);
      m = int'(v.cmp) + 1;
      if (v.clr == 3'd1) return 16'((base + t) % m);
      return 16'(base + t);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: got=timeout expected=completion");
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0]  b;
      logic [15:0] w;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // ---- R1 reset state ----
      chk("R1 pin", {31'b0, cmp_pin}, 0);
      chk("R1 pin_oe", {31'b0, cmp_pin_oe}, 0);
      chk("R1 irq", {31'b0, irq}, 0);
      rd(4'd0, b);  chk("R1 ctrl", b, 8'h00);
      rd(4'd2, b);  chk("R1 ioc", b, 8'h00);
      rd(4'd5, b);  chk("R1 status", b, 8'h00);
      rd16(4'd6, w); chk("R1 counter", w, 16'h0000);
      rd16(4'd8, w); chk("R1 compare", w, 16'hFFFF);

      // ---- R10 register map ----
      wr(4'd1, 8'hFF); rd(4'd1, b); chk("R10 mode low nibble", b, 8'h0F);
      wr(4'd4, 8'hA6); rd(4'd4, b); chk("R10 ier readback", b, 8'hA6);
      wr(4'd3, 8'h5A); rd(4'd3, b); chk("R10 unused offset", b, 8'h00);
      wr(4'd2, 8'h70); rd(4'd2, b); chk("R10 ioc readback", b, 8'h70);
      chk("R8 high nibble does not drive pin", {31'b0, cmp_pin_oe}, 0);
      wr(4'd2, 8'h00);
      wr(4'd4, 8'h00);

      // ---- table: R3 prescale, R4 clear/wrap ----
      foreach (VECS[i]) begin
         vec_t v;
         v = VECS[i];
         setup({v.clr, 2'b00, v.psc}, v.cmp, v.init);
         run(int'(v.cyc));
         rd16(4'd6, w);
         chk((v.clr == 3'd1 || v.init != 16'h0) ? "R4 table count" : "R3 table count",
             w, expect_cnt(v));
      end

      // ---- R2 stopped channel holds ----
      repeat (10) @(negedge clk);
      rd16(4'd6, w); chk("R2 held while stopped", w, 16'h0003);
      setup(8'h01, 16'hFFFF, 16'h0000);
      run(3);
      rd16(4'd6, w); chk("R2 divider restarts", w, 16'h0000);
      run(3);
      rd16(4'd6, w); chk("R2 divider restarts again", w, 16'h0000);

      // ---- R6 clear the flag left by table matches ----
      rd(4'd5, b); chk("R5 flag from table match", b, 8'h01);
      wr(4'd5, 8'h00);
      rd(4'd5, b); chk("R6 read then zero clears", b, 8'h00);

      // ---- R5/R7/R6 handshake ----
      wr(4'd4, 8'h01);
      setup(8'h20, 16'h0005, 16'h0000);
      chk("R7 irq low before match", {31'b0, irq}, 0);
      run(5);
      chk("R5 no match before compare", {31'b0, irq}, 0);
      run(1);
      chk("R5 match sets flag", {31'b0, irq}, 1);
      rd16(4'd6, w); chk("R4 cleared at compare", w, 16'h0000);
      wr(4'd4, 8'h00); chk("R7 masked", {31'b0, irq}, 0);
      wr(4'd4, 8'h01); chk("R7 unmasked", {31'b0, irq}, 1);
      wr(4'd5, 8'h00); chk("R6 zero without read ignored", {31'b0, irq}, 1);
      rd(4'd5, b);     chk("R10 status bit0", b, 8'h01);
      wr(4'd5, 8'h01); chk("R6 write one ignored", {31'b0, irq}, 1);
      wr(4'd5, 8'h00); chk("R6 arm dropped by write", {31'b0, irq}, 1);
      rd(4'd5, b);
      wr(4'd5, 8'h00); chk("R6 handshake clears", {31'b0, irq}, 0);
      wr(4'd4, 8'h00);

      // ---- R8 pin actions ----
      setup(8'h20, 16'h0005, 16'h0000);
      wr(4'd2, 8'h03);
      chk("R8 toggle init level", {30'b0, cmp_pin_oe, cmp_pin}, 32'h2);
      run(6);
      chk("R8 toggle first match", {30'b0, cmp_pin_oe, cmp_pin}, 32'h3);
      run(6);
      chk("R8 toggle second match", {30'b0, cmp_pin_oe, cmp_pin}, 32'h2);
      wr(4'd2, 8'h05);
      chk("R8 init level one", {31'b0, cmp_pin}, 1);
      run(6);
      chk("R8 clear on match", {31'b0, cmp_pin}, 0);
      wr(4'd2, 8'h06);
      run(6);
      chk("R8 set on match", {31'b0, cmp_pin}, 1);
      wr(4'd2, 8'h04);
      chk("R8 code four disabled", {30'b0, cmp_pin_oe, cmp_pin}, 0);
      wr(4'd2, 8'h00);
      chk("R8 code zero disabled", {30'b0, cmp_pin_oe, cmp_pin}, 0);

      // ---- R9 write beats a running tick ----
      setup(8'h00, 16'hFFFF, 16'h1200);
      start_vec[CH] = 1'b1;
      reg_wr = 1'b1; reg_addr = 4'd7; reg_wdata = 8'h55;
      @(negedge clk);
      reg_wr = 1'b0;
      start_vec[CH] = 1'b0;
      rd16(4'd6, w); chk("R9 write wins over tick", w, 16'h1255);
      setup(8'h20, 16'h1255, 16'h1255);
      wr(4'd2, 8'h03);
      start_vec[CH] = 1'b1;
      reg_wr = 1'b1; reg_addr = 4'd7; reg_wdata = 8'h55;
      @(negedge clk);
      reg_wr = 1'b0;
      start_vec[CH] = 1'b0;
      chk("R9 no match event during write", {31'b0, cmp_pin}, 0);
      rd16(4'd6, w); chk("R9 no clear during write", w, 16'h1255);

      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule